// File: doc/BRIEF.md
# Shared SDRAM Bus Ownership Arbiter

This block decides who drives a shared SDRAM bus: the chip's own memory controller or an external unified-memory device. The external device asks for the bus with an active-low request line and a priority bit that is sampled with it. The block answers on an active-low grant line. A low-priority request is granted only once the internal controller reports no pending transaction. A high-priority request is granted within a hard bound. While that request waits, new internal transactions are held back. If the internal controller still has not gone idle when the bound runs out, the grant is forced.

Once granted, the external device keeps the bus for as long as it holds its request, with no timeout. Releasing the request returns the bus at the next clock edge. After a release the request line must stay inactive for a minimum gap before it counts as a new request. An early re-raise is ignored and latches a sticky error flag. While the bus is away, the block does the following:
- It raises a request-back indication.
- When enabled, it shows on a total-request output whether real internal demand is waiting.
- It stalls internal register reads and internal refresh.

A configuration bit can switch internal refresh off entirely.

Top module: `membus_owner_arb`

## Requirements
- R1: After synchronous active-high reset, the grant is inactive (extGntN = 1), the spacing error flag is 0, reqBack is 0 and intStartOk is 1. A request already active at the first edge after reset is accepted.
- R2: A low-priority request (extHiPri = 0) accepted at edge E0 is granted at the first later edge that samples intPending = 0. The grant is visible after that edge, and never earlier than after E1.
- R3: While the request stays active, the grant stays active for any number of cycles, whatever intPending does.
- R4: The edge that samples extReqN = 1 also clears the grant.
- R5: After a release, the request must be sampled inactive on at least MIN_GAP (default 2) edges before a new request is accepted. A rise that comes sooner gets no grant for as long as it is held, and it sets spacingErr, which then stays 1 until reset.
- R6: If a request is accepted at edge E0 with extHiPri = 1 and intPending stays 1, the grant is forced after edge E(HI_MAX-1). The default HI_MAX is 35. If intPending drops earlier, the grant follows as in R2.
- R7: If a request starts low priority and extHiPri is first sampled 1 at edge EL, the bound counts from EL. In that case the forced grant comes after edge E(L+HI_MAX-1).
- R8: intStartOk is 0 while the grant is active, and also while an accepted high-priority request waits.
- R9: reqBack is 1 exactly while the grant is active.
- R10: totalReq = cfgTotalReqEn AND grant active AND (intNewReq OR regRdReq OR (refreshReq AND NOT cfgRefreshOff)).
- R11: refreshGo = refreshReq AND NOT cfgRefreshOff AND grant inactive.
- R12: regRdGo = regRdReq AND grant inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| extReqN | input | 1 | External device bus request, active low |
| extHiPri | input | 1 | Request priority, 1 = high, sampled with extReqN |
| extGntN | output | 1 | Bus grant to the external device, active low |
| intPending | input | 1 | Internal controller has a transaction in progress or queued |
| intNewReq | input | 1 | Internal agent wants to start a new transaction |
| intStartOk | output | 1 | A new internal transaction may start |
| regRdReq | input | 1 | Internal register read waiting |
| regRdGo | output | 1 | Register read may proceed |
| refreshReq | input | 1 | Internal refresh engine wants a refresh cycle |
| refreshGo | output | 1 | Refresh cycle may be issued |
| cfgTotalReqEn | input | 1 | Enables the total-request output |
| cfgRefreshOff | input | 1 | Disables internal refresh |
| totalReq | output | 1 | Real internal demand waiting while the bus is away |
| reqBack | output | 1 | Controller asks for the bus back |
| spacingErr | output | 1 | Sticky flag: request re-raised too soon |

## Verification
Low-priority requests are swept against busy periods of zero to five cycles. Each busy length must move the grant edge by exactly that many cycles, which separates the idle-wait rule from a fixed delay. High-priority requests are run with the controller never going idle, and once with the priority rising late. These runs show whether the bound is forced at the right edge and whether it counts from the priority change rather than from the request. Gaps of one to three inactive cycles before a re-raise separate accepted requests from ignored ones and check the sticky flag. An exhaustive sweep of the side-band inputs, with the grant on and off, covers every combination of the gating outputs.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;

  // Status the datapath reports to the control each cycle
  typedef struct packed {
    logic reqSeen;  // request sampled active this cycle
    logic reqRise;  // request went active since the last edge
    logic gapOk;    // spacing window after the last release has run out
    logic hiSeen;   // priority input sampled high
    logic ageDone;  // high-priority wait has reached its bound
  } dpStat_t;

  // Strobes the control sends to the datapath
  typedef struct packed {
    logic ageRun;   // a high-priority request is waiting for the grant
  } ctlStrobe_t;

endpackage

// File: rtl/mbarb_dp.sv
module mbarb_dp
  import mbarb_pkg::*;
#(
  parameter int MIN_GAP = 2,
  parameter int HI_MAX  = 35
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extReqN,
  input  logic       extHiPri,
  input  ctlStrobe_t strobe,
  output dpStat_t    stat,
  output logic       spacingErr
);

  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam int AGE_W = $clog2(HI_MAX + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP - 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(HI_MAX - 1);

  logic             prevReqQ;
  logic [GAP_W-1:0] holdQ;
  logic [AGE_W-1:0] ageQ;
  logic             errQ;

  assign stat.reqSeen = !extReqN;
  assign stat.reqRise = !extReqN && !prevReqQ;
  assign stat.gapOk   = (holdQ == '0);
  assign stat.hiSeen  = extHiPri;
  assign stat.ageDone = (ageQ == AGE_LAST);
  assign spacingErr   = errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevReqQ <= 1'b0;
      holdQ    <= '0;
      ageQ     <= '0;
      errQ     <= 1'b0;
    end else begin
      prevReqQ <= !extReqN;
      // spacing window: loaded on release, counts down while inactive
      if (prevReqQ && extReqN)
        holdQ <= GAP_LOAD;
      else if (extReqN && holdQ != '0)
        holdQ <= holdQ - GAP_W'(1);
      // high-priority wait age, saturating at the bound
      if (strobe.ageRun)
        ageQ <= (ageQ == AGE_LAST) ? ageQ : ageQ + AGE_W'(1);
      else
        ageQ <= '0;
      if (stat.reqRise && !stat.gapOk)
        errQ <= 1'b1;
    end
  end

  a_r6_age_cap: assert property (@(posedge clk) disable iff (rst)
    ageQ <= AGE_LAST);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    errQ |=> errQ);

  a_r5_hold_range: assert property (@(posedge clk) disable iff (rst)
    holdQ <= GAP_LOAD);

endmodule

// File: rtl/mbarb_ctrl.sv
module mbarb_ctrl
  import mbarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpStat_t    stat,
  input  logic       intPending,
  input  logic       intNewReq,
  input  logic       regRdReq,
  input  logic       refreshReq,
  input  logic       cfgTotalReqEn,
  input  logic       cfgRefreshOff,
  output ctlStrobe_t strobe,
  output logic       gntOut,
  output logic       intStartOk,
  output logic       regRdGo,
  output logic       refreshGo,
  output logic       totalReq,
  output logic       reqBack
);

  logic liveQ, hiQ, gntQ;
  logic accept, liveNext, forceGnt, gntNext;

  assign accept   = stat.reqRise && stat.gapOk;
  assign liveNext = stat.reqSeen && (liveQ || accept);
  assign forceGnt = stat.hiSeen && stat.ageDone;
  assign gntNext  = stat.reqSeen && (gntQ || (liveQ && (!intPending || forceGnt)));

  assign strobe.ageRun = liveNext && stat.hiSeen && !gntNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      liveQ <= 1'b0;
      hiQ   <= 1'b0;
      gntQ  <= 1'b0;
    end else begin
      liveQ <= liveNext;
      hiQ   <= liveNext && stat.hiSeen;
      gntQ  <= gntNext;
    end
  end

  assign gntOut     = gntQ;
  assign reqBack    = gntQ;
  assign intStartOk = !gntQ && !(liveQ && hiQ);
  assign regRdGo    = regRdReq && !gntQ;
  assign refreshGo  = refreshReq && !cfgRefreshOff && !gntQ;
  assign totalReq   = cfgTotalReqEn && gntQ &&
                      (intNewReq || regRdReq || (refreshReq && !cfgRefreshOff));

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    !stat.reqSeen |=> !gntQ);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (gntQ && stat.reqSeen) |=> gntQ);

  a_r2_low_needs_idle: assert property (@(posedge clk) disable iff (rst)
    ($rose(gntQ) && !$past(stat.hiSeen)) |-> !$past(intPending));

  a_r5_grant_needs_live: assert property (@(posedge clk) disable iff (rst)
    $rose(gntQ) |-> $past(liveQ));

endmodule

// File: rtl/membus_owner_arb.sv
module membus_owner_arb
  import mbarb_pkg::*;
#(
  parameter int MIN_GAP = 2,
  parameter int HI_MAX  = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic extReqN,
  input  logic extHiPri,
  output logic extGntN,
  input  logic intPending,
  input  logic intNewReq,
  output logic intStartOk,
  input  logic regRdReq,
  output logic regRdGo,
  input  logic refreshReq,
  output logic refreshGo,
  input  logic cfgTotalReqEn,
  input  logic cfgRefreshOff,
  output logic totalReq,
  output logic reqBack,
  output logic spacingErr
);

  dpStat_t    stat;
  ctlStrobe_t strobe;
  logic       gntOut;

  mbarb_dp #(.MIN_GAP(MIN_GAP), .HI_MAX(HI_MAX)) dpInst (
    .clk(clk), .rst(rst), .extReqN(extReqN), .extHiPri(extHiPri),
    .strobe(strobe), .stat(stat), .spacingErr(spacingErr)
  );

  mbarb_ctrl ctrlInst (
    .clk(clk), .rst(rst), .stat(stat), .intPending(intPending),
    .intNewReq(intNewReq), .regRdReq(regRdReq), .refreshReq(refreshReq),
    .cfgTotalReqEn(cfgTotalReqEn), .cfgRefreshOff(cfgRefreshOff),
    .strobe(strobe), .gntOut(gntOut), .intStartOk(intStartOk),
    .regRdGo(regRdGo), .refreshGo(refreshGo), .totalReq(totalReq),
    .reqBack(reqBack)
  );

  assign extGntN = !gntOut;

  a_r8_start_blocked: assert property (@(posedge clk) disable iff (rst)
    !extGntN |-> !intStartOk);

endmodule

// File: tb/membus_owner_arb_test.sv
`timescale 1ns/1ps
module membus_owner_arb_test;

  localparam int HI_MAX = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extReqN = 1'b1, extHiPri = 1'b0, intPending = 1'b0, intNewReq = 1'b0;
  logic regRdReq = 1'b0, refreshReq = 1'b0, cfgTotalReqEn = 1'b0, cfgRefreshOff = 1'b0;
  logic extGntN, intStartOk, regRdGo, refreshGo, totalReq, reqBack, spacingErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  membus_owner_arb #(.MIN_GAP(2), .HI_MAX(HI_MAX)) uut (
    .clk(clk), .rst(rst), .extReqN(extReqN), .extHiPri(extHiPri), .extGntN(extGntN),
    .intPending(intPending), .intNewReq(intNewReq), .intStartOk(intStartOk),
    .regRdReq(regRdReq), .regRdGo(regRdGo), .refreshReq(refreshReq),
    .refreshGo(refreshGo), .cfgTotalReqEn(cfgTotalReqEn), .cfgRefreshOff(cfgRefreshOff),
    .totalReq(totalReq), .reqBack(reqBack), .spacingErr(spacingErr)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    extReqN = 1'b1; extHiPri = 1'b0; intPending = 1'b0;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish();
    end
  end

  initial begin
    // R1: reset state
    doReset();
    check(extGntN == 1'b1, "R1 grant after reset", extGntN, 1);
    check(spacingErr == 1'b0, "R1 error after reset", spacingErr, 0);
    check(reqBack == 1'b0, "R1 reqBack after reset", reqBack, 0);
    check(intStartOk == 1'b1, "R1 intStartOk after reset", intStartOk, 1);

    // R2 / R4: low priority with busy periods 0..5
    for (int d = 0; d <= 5; d++) begin
      int firstG;
      doReset();
      firstG = (d > 1) ? d : 1;
      extReqN = 1'b0;
      intPending = (d > 0);
      for (int k = 0; k <= 7; k++) begin
        tick();
        check((extGntN == 1'b0) == (k >= firstG), "R2 low grant edge",
              int'(!extGntN), int'(k >= firstG));
        intPending = (k + 1 < d);
      end
      check(reqBack == 1'b1, "R9 reqBack while granted", reqBack, 1);
      extReqN = 1'b1;
      tick();
      check(extGntN == 1'b1, "R4 release next edge", extGntN, 1);
      check(reqBack == 1'b0, "R9 reqBack after release", reqBack, 0);
    end

    // R5: re-request spacing
    for (int g = 1; g <= 3; g++) begin
      bit okGap;
      okGap = (g >= 2);
      doReset();
      extReqN = 1'b0;
      tick(); tick();
      check(extGntN == 1'b0, "R5 first grant", extGntN, 0);
      extReqN = 1'b1;
      for (int i = 0; i < g; i++) tick();
      check(extGntN == 1'b1, "R5 released", extGntN, 1);
      extReqN = 1'b0;
      tick(); tick();
      check((extGntN == 1'b0) == okGap, "R5 re-raise grant", int'(!extGntN), int'(okGap));
      check(spacingErr == !okGap, "R5 spacing error", spacingErr, int'(!okGap));
      tick(); tick(); tick();
      check((extGntN == 1'b0) == okGap, "R5 early request stays ignored",
            int'(!extGntN), int'(okGap));
      extReqN = 1'b1;
      tick(); tick(); tick();
      check(spacingErr == !okGap, "R5 error sticky", spacingErr, int'(!okGap));
    end

    // R6 / R8: high priority, controller never idle
    doReset();
    extHiPri = 1'b1; intPending = 1'b1; extReqN = 1'b0;
    for (int k = 0; k <= HI_MAX + 1; k++) begin
      tick();
      check((extGntN == 1'b0) == (k >= HI_MAX - 1), "R6 forced grant edge",
            int'(!extGntN), int'(k >= HI_MAX - 1));
      if (k == 0) check(intStartOk == 1'b0, "R8 held back while high waits", intStartOk, 0);
    end
    check(intStartOk == 1'b0, "R8 held back while granted", intStartOk, 0);
    extReqN = 1'b1; extHiPri = 1'b0; intPending = 1'b0;
    tick();
    check(intStartOk == 1'b1, "R8 start allowed after release", intStartOk, 1);

    // R6: high priority, controller goes idle after 5 edges
    doReset();
    extHiPri = 1'b1; intPending = 1'b1; extReqN = 1'b0;
    for (int k = 0; k <= 8; k++) begin
      tick();
      check((extGntN == 1'b0) == (k >= 5), "R6 early idle grant",
            int'(!extGntN), int'(k >= 5));
      intPending = (k + 1 < 5);
    end
    extReqN = 1'b1; extHiPri = 1'b0;
    tick();

    // R7: priority raised late
    for (int li = 0; li < 2; li++) begin
      int lv;
      lv = (li == 0) ? 2 : 5;
      doReset();
      extHiPri = 1'b0; intPending = 1'b1; extReqN = 1'b0;
      for (int k = 0; k <= lv + HI_MAX + 1; k++) begin
        tick();
        check((extGntN == 1'b0) == (k >= lv + HI_MAX - 1), "R7 bound from priority change",
              int'(!extGntN), int'(k >= lv + HI_MAX - 1));
        extHiPri = (k + 1 >= lv);
      end
      extReqN = 1'b1; extHiPri = 1'b0; intPending = 1'b0;
      tick();
    end

    // R3: no ownership timeout
    doReset();
    extReqN = 1'b0;
    tick(); tick();
    for (int k = 0; k < 300; k++) begin
      intPending = k[2];
      tick();
    end
    check(extGntN == 1'b0, "R3 grant kept", extGntN, 0);
    check(reqBack == 1'b1, "R9 reqBack kept", reqBack, 1);
    intPending = 1'b0;

    // R10 / R11 / R12: side-band sweep, granted then released
    for (int ph = 0; ph < 2; ph++) begin
      bit gnt;
      gnt = (ph == 0);
      for (int v = 0; v < 32; v++) begin
        bit expT, expR, expD;
        cfgTotalReqEn = v[0]; intNewReq = v[1]; regRdReq = v[2];
        refreshReq = v[3]; cfgRefreshOff = v[4];
        #1;
        expT = v[0] && gnt && (v[1] || v[2] || (v[3] && !v[4]));
        expR = v[3] && !v[4] && !gnt;
        expD = v[2] && !gnt;
        check(totalReq == expT, "R10 totalReq", totalReq, int'(expT));
        check(refreshGo == expR, "R11 refreshGo", refreshGo, int'(expR));
        check(regRdGo == expD, "R12 regRdGo", regRdGo, int'(expD));
      end
      if (ph == 0) begin
        extReqN = 1'b1;
        tick();
      end
    end

    finished = 1;
    finish();
  end

endmodule